// File: doc/BRIEF.md
# Timer channel with status flags

This block is one channel of a 16-bit up/down timer. It has two general registers, A and B, and an 8-bit status byte. The counter steps once per cycle while it is enabled. An input selects up or down counting. A bus strobe can load the counter directly. Each general register works in one of two modes. In output-compare mode it raises its flag when the counter reaches its value. In input-capture mode it copies the counter on a rising edge of its capture input and raises its flag. Two more flags record a wrap from all-ones to zero and a wrap from zero to all-ones.

Software clears a flag in two steps. First it reads the status byte while the flag is 1. Then it writes a 0 to that bit. A 0 write without that prior read does nothing. Flag A has a second clear path: a DMA acknowledge pulse. Each flag, gated by its own enable input, drives an interrupt request.

Top module: `tmr_chan_status`

## Requirements
- R1: After a synchronous reset (rst_n low at a clock edge), the status byte reads 0xC0, the counter and both general registers are 0, and every interrupt output is 0.
- R2: `cnt_ld` loads `wdata` into the counter and has priority over counting. Otherwise, while `cnt_en` is 1, the counter adds 1 when `cnt_up` is 1 and subtracts 1 when it is 0. Status bit 7 shows `cnt_up` as it was at the previous clock edge (1 = up, 0 = down).
- R3: Status bit 6 always reads 1 and bits 3 and 2 always read 0. Writes to bits 7, 6, 3 and 2 change nothing.
- R4: Status bit 4 (overflow) becomes 1 after an enabled up-step from 0xFFFF to 0x0000.
- R5: Status bit 5 (underflow) becomes 1 after an enabled down-step from 0x0000 to 0xFFFF.
- R6: In compare mode (`mode_x_cap` = 0), status bit 0 (A) or bit 1 (B) becomes 1 one cycle after the counter first equals that general register. If the counter stays on that value, the flag is not set again.
- R7: In capture mode (`mode_x_cap` = 1), a rising edge on `cap_x_in` copies the counter into the register and sets its flag one edge later. A level that stays high does not capture again. A counter match in capture mode sets nothing.
- R8: A 0 written to flag bit 5, 4, 1 or 0 clears that flag only if a status read returned the flag as 1 after the previous status write. Every status write uses up the read. Writing 1 never changes a flag.
- R9: A `dma_ack_a` pulse clears flag A and leaves the other flags unchanged.
- R10: When a flag's set condition and a clear (by write or by DMA acknowledge) happen in the same cycle, the flag stays 1.
- R11: Each interrupt output (`irq_a`, `irq_b`, `irq_ovf`, `irq_unf`) is 1 exactly when its flag and its enable input are both 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| cnt_en | input | 1 | Counter step enable |
| cnt_up | input | 1 | Count direction, 1 = up |
| cnt_ld | input | 1 | Load the counter from wdata |
| wdata | input | 16 | Write data for the counter and the general registers |
| gr_wr_a | input | 1 | Write wdata into general register A |
| gr_wr_b | input | 1 | Write wdata into general register B |
| mode_a_cap | input | 1 | Register A mode, 1 = input capture |
| mode_b_cap | input | 1 | Register B mode, 1 = input capture |
| cap_a_in | input | 1 | Capture input A, acts on its rising edge |
| cap_b_in | input | 1 | Capture input B, acts on its rising edge |
| st_rd | input | 1 | Status read strobe |
| st_wr | input | 1 | Status write strobe |
| st_wdata | input | 8 | Status write data |
| dma_ack_a | input | 1 | DMA acknowledge, clears flag A |
| ie_a | input | 1 | Interrupt enable for flag A |
| ie_b | input | 1 | Interrupt enable for flag B |
| ie_ovf | input | 1 | Interrupt enable for overflow |
| ie_unf | input | 1 | Interrupt enable for underflow |
| cnt_q | output | 16 | Counter value |
| gr_a_q | output | 16 | General register A |
| gr_b_q | output | 16 | General register B |
| stat_rdata | output | 8 | Status byte |
| irq_a | output | 1 | Interrupt request A |
| irq_b | output | 1 | Interrupt request B |
| irq_ovf | output | 1 | Overflow interrupt request |
| irq_unf | output | 1 | Underflow interrupt request |

## Verification
The hardest case to reach is a set event and a clear landing on the same clock edge. The flag has to be 1 and already read, so that the clear is armed. Then the counter has to arrive on a compare value exactly when the zero write or DMA acknowledge is presented. The stimulus sets the flag and reads it to arm the clear. It reloads the counter one below the compare value and enables a single step. On the following cycle, when the registered match detection fires, it drives the write or the acknowledge. A second hard case is the single-fire rule for compare. The bench clears a flag while the counter is parked on the match value and shows that the flag stays clear.

// File: rtl/tmr_chan_status.sv
module tmr_chan_status #(
  parameter int CW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cnt_en,
  input  logic          cnt_up,
  input  logic          cnt_ld,
  input  logic [CW-1:0] wdata,
  input  logic          gr_wr_a,
  input  logic          gr_wr_b,
  input  logic          mode_a_cap,
  input  logic          mode_b_cap,
  input  logic          cap_a_in,
  input  logic          cap_b_in,
  input  logic          st_rd,
  input  logic          st_wr,
  input  logic [7:0]    st_wdata,
  input  logic          dma_ack_a,
  input  logic          ie_a,
  input  logic          ie_b,
  input  logic          ie_ovf,
  input  logic          ie_unf,
  output logic [CW-1:0] cnt_q,
  output logic [CW-1:0] gr_a_q,
  output logic [CW-1:0] gr_b_q,
  output logic [7:0]    stat_rdata,
  output logic          irq_a,
  output logic          irq_b,
  output logic          irq_ovf,
  output logic          irq_unf
);
  localparam logic [CW-1:0] CNT_MAX = '1;
  localparam int NGR = 2;
  // flag vector order: [3]=underflow [2]=overflow [1]=B [0]=A
  localparam int NFLG = 4;

  logic [CW-1:0] cnt;
  logic          dir_q;
  logic          step;
  logic          wrap_hi, wrap_lo;

  logic [CW-1:0] gr [NGR];
  logic [NGR-1:0] cap_mode, cap_in, cap_q, gr_wr, match, match_q, cap_evt, gr_set;

  logic [NFLG-1:0] flg, arm, set_v, wbit, clr_v;
  logic unused_wbits;

  assign step    = cnt_en & ~cnt_ld;
  assign wrap_hi = step &  cnt_up & (cnt == CNT_MAX);
  assign wrap_lo = step & ~cnt_up & (cnt == '0);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt   <= '0;
      dir_q <= 1'b1;
    end else begin
      dir_q <= cnt_up;
      if (cnt_ld)
        cnt <= wdata;
      else if (cnt_en)
        cnt <= cnt_up ? cnt + 1'b1 : cnt - 1'b1;
    end
  end

  assign cap_mode = {mode_b_cap, mode_a_cap};
  assign cap_in   = {cap_b_in, cap_a_in};
  assign gr_wr    = {gr_wr_b, gr_wr_a};

  for (genvar g = 0; g < NGR; g++) begin : g_gr
    assign match[g]   = ~cap_mode[g] & (cnt == gr[g]);
    assign cap_evt[g] =  cap_mode[g] & cap_in[g] & ~cap_q[g];
    assign gr_set[g]  = cap_evt[g] | (match[g] & ~match_q[g]);

    always_ff @(posedge clk) begin
      if (!rst_n) begin
        gr[g]      <= '0;
        cap_q[g]   <= 1'b0;
        match_q[g] <= 1'b1;
      end else begin
        cap_q[g]   <= cap_in[g];
        match_q[g] <= match[g];
        if (cap_evt[g])
          gr[g] <= cnt;
        else if (gr_wr[g])
          gr[g] <= wdata;
      end
    end
  end

  assign set_v = {wrap_lo, wrap_hi, gr_set[1], gr_set[0]};
  assign wbit  = {st_wdata[5], st_wdata[4], st_wdata[1], st_wdata[0]};
  assign clr_v = (st_wr ? (arm & ~wbit) : '0) | {{(NFLG-1){1'b0}}, dma_ack_a};
  assign unused_wbits = ^{st_wdata[7:6], st_wdata[3:2]};

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      flg <= '0;
      arm <= '0;
    end else begin
      flg <= set_v | (flg & ~clr_v);
      if (st_wr)
        arm <= '0;
      else if (st_rd)
        arm <= arm | flg;
      else
        arm <= arm & flg;
    end
  end

  assign cnt_q      = cnt;
  assign gr_a_q     = gr[0];
  assign gr_b_q     = gr[1];
  assign stat_rdata = {dir_q, 1'b1, flg[3], flg[2], 2'b00, flg[1], flg[0]};

  assign irq_a   = flg[0] & ie_a;
  assign irq_b   = flg[1] & ie_b;
  assign irq_ovf = flg[2] & ie_ovf;
  assign irq_unf = flg[3] & ie_unf;
endmodule

// File: rtl/tmr_chan_status_chk.sv
module tmr_chan_status_chk #(
  parameter int CW = 16
) (
  input logic          clk,
  input logic          rst_n,
  input logic          cnt_en,
  input logic          cnt_up,
  input logic          cnt_ld,
  input logic          gr_wr_a,
  input logic          mode_a_cap,
  input logic          cap_a_in,
  input logic          st_wr,
  input logic [7:0]    st_wdata,
  input logic          dma_ack_a,
  input logic          ie_ovf,
  input logic [CW-1:0] cnt_q,
  input logic [CW-1:0] gr_a_q,
  input logic [7:0]    stat_rdata,
  input logic          irq_ovf
);
  localparam logic [CW-1:0] CMAX = '1;

  a_r2_dir_follows: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_up |=> stat_rdata[7]);

  a_r4_overflow_set: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt_en && cnt_up && !cnt_ld && cnt_q == CMAX) |=> (stat_rdata[4] && cnt_q == '0));

  a_r5_underflow_set: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt_en && !cnt_up && !cnt_ld && cnt_q == '0) |=> (stat_rdata[5] && cnt_q == CMAX));

  a_r6_compare_set: assert property (@(posedge clk) disable iff (!rst_n)
    (!mode_a_cap && $stable(mode_a_cap) && cnt_q == gr_a_q && !$stable(cnt_q) && $stable(gr_a_q))
      |=> stat_rdata[0]);

  a_r7_capture_load: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_a_cap && cap_a_in && !$past(cap_a_in) && !gr_wr_a)
      |=> (stat_rdata[0] && gr_a_q == $past(cnt_q)));

  a_r8_ovf_keeps: assert property (@(posedge clk) disable iff (!rst_n)
    (stat_rdata[4] && !(st_wr && !st_wdata[4])) |=> stat_rdata[4]);

  a_r8_a_keeps: assert property (@(posedge clk) disable iff (!rst_n)
    (stat_rdata[0] && !(st_wr && !st_wdata[0]) && !dma_ack_a) |=> stat_rdata[0]);

  a_r11_ovf_irq_gated: assert property (@(posedge clk) disable iff (!rst_n)
    irq_ovf |-> (ie_ovf && stat_rdata[4]));
endmodule

bind tmr_chan_status tmr_chan_status_chk #(.CW(CW)) u_chk (
  .clk(clk), .rst_n(rst_n), .cnt_en(cnt_en), .cnt_up(cnt_up), .cnt_ld(cnt_ld),
  .gr_wr_a(gr_wr_a), .mode_a_cap(mode_a_cap), .cap_a_in(cap_a_in),
  .st_wr(st_wr), .st_wdata(st_wdata), .dma_ack_a(dma_ack_a), .ie_ovf(ie_ovf),
  .cnt_q(cnt_q), .gr_a_q(gr_a_q), .stat_rdata(stat_rdata), .irq_ovf(irq_ovf)
);

// File: tb/test_tmr_chan_status.sv
`timescale 1ns/1ps
module test_tmr_chan_status;
  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic rst_n, cnt_en, cnt_up, cnt_ld, gr_wr_a, gr_wr_b, mode_a_cap, mode_b_cap;
  logic cap_a_in, cap_b_in, st_rd, st_wr, dma_ack_a, ie_a, ie_b, ie_ovf, ie_unf;
  logic [15:0] wdata;
  logic [7:0]  st_wdata;
  logic [15:0] cnt_q, gr_a_q, gr_b_q;
  logic [7:0]  stat_rdata;
  logic irq_a, irq_b, irq_ovf, irq_unf;

  tmr_chan_status i_tmr_chan_status (
    .clk(clk), .rst_n(rst_n), .cnt_en(cnt_en), .cnt_up(cnt_up), .cnt_ld(cnt_ld),
    .wdata(wdata), .gr_wr_a(gr_wr_a), .gr_wr_b(gr_wr_b),
    .mode_a_cap(mode_a_cap), .mode_b_cap(mode_b_cap),
    .cap_a_in(cap_a_in), .cap_b_in(cap_b_in), .st_rd(st_rd), .st_wr(st_wr),
    .st_wdata(st_wdata), .dma_ack_a(dma_ack_a), .ie_a(ie_a), .ie_b(ie_b),
    .ie_ovf(ie_ovf), .ie_unf(ie_unf), .cnt_q(cnt_q), .gr_a_q(gr_a_q),
    .gr_b_q(gr_b_q), .stat_rdata(stat_rdata), .irq_a(irq_a), .irq_b(irq_b),
    .irq_ovf(irq_ovf), .irq_unf(irq_unf)
  );

  int n_chk = 0;
  int n_err = 0;
  logic [7:0] rv;

  // {load value, up, steps, expected counter, expected status}
  localparam int NV = 6;
  localparam logic [48:0] VEC [NV] = '{
    {16'h1000, 1'b1, 8'd5, 16'h1005, 8'hC0},
    {16'hFFFE, 1'b1, 8'd3, 16'h0001, 8'hD0},
    {16'h0001, 1'b0, 8'd3, 16'hFFFE, 8'h60},
    {16'h8000, 1'b0, 8'd1, 16'h7FFF, 8'h40},
    {16'hFFFF, 1'b1, 8'd1, 16'h0000, 8'hD0},
    {16'h0000, 1'b0, 8'd1, 16'hFFFF, 8'h60}
  };

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic rd(output logic [7:0] v);
    st_rd = 1'b1; v = stat_rdata; cyc(1); st_rd = 1'b0;
  endtask

  task automatic wr(input logic [7:0] d);
    st_wr = 1'b1; st_wdata = d; cyc(1); st_wr = 1'b0;
  endtask

  task automatic ld(input logic [15:0] v, input logic up);
    cnt_ld = 1'b1; wdata = v; cnt_up = up; cyc(1); cnt_ld = 1'b0;
  endtask

  task automatic run(input int n);
    cnt_en = 1'b1; cyc(n); cnt_en = 1'b0;
  endtask

  task automatic grw(input logic sel_b, input logic [15:0] v);
    wdata = v; gr_wr_a = ~sel_b; gr_wr_b = sel_b; cyc(1);
    gr_wr_a = 1'b0; gr_wr_b = 1'b0;
  endtask

  task automatic clr_all();
    logic [7:0] t;
    rd(t); wr(8'h00);
  endtask

  task automatic summary();
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_chk++; n_err++;
    $display("FAIL watchdog expired");
    summary();
  end

  initial begin
    rst_n = 1'b0; cnt_en = 0; cnt_up = 1; cnt_ld = 0; gr_wr_a = 0; gr_wr_b = 0;
    mode_a_cap = 1; mode_b_cap = 1; cap_a_in = 0; cap_b_in = 0; st_rd = 0; st_wr = 0;
    dma_ack_a = 0; ie_a = 1; ie_b = 0; ie_ovf = 1; ie_unf = 0; wdata = '0; st_wdata = '0;
    cyc(3);
    rst_n = 1'b1;
    cyc(1);

    // R1 reset state
    chk("R1 status", stat_rdata, 8'hC0);
    chk("R1 counter", cnt_q, 0);
    chk("R1 gr a/b", {gr_a_q, gr_b_q}, 0);
    chk("R1 irqs", {irq_a, irq_b, irq_ovf, irq_unf}, 0);

    // R3 reserved and one-writes
    wr(8'hFF);
    chk("R3 write ones", stat_rdata, 8'hC0);
    rd(rv); wr(8'h00);
    chk("R3 write zeros", stat_rdata, 8'hC0);

    // R2 R4 R5 vector table
    for (int i = 0; i < NV; i++) begin
      ld(VEC[i][48:33], VEC[i][32]);
      run(int'(VEC[i][31:24]));
      chk("R2 counter value", cnt_q, VEC[i][23:8]);
      chk("R4/R5 status", stat_rdata, VEC[i][7:0]);
      clr_all();
    end

    // R6 compare
    mode_a_cap = 0; mode_b_cap = 0;
    grw(1'b0, 16'h0010);
    grw(1'b1, 16'h0012);
    ld(16'h000E, 1'b1);
    run(2);
    chk("R6 not yet set", stat_rdata, 8'hC0);
    cyc(1);
    chk("R6 flag A set", stat_rdata, 8'hC1);
    chk("R11 irq_a/irq_b", {irq_a, irq_b}, 2'b10);
    rd(rv); wr(8'h00);
    chk("R8 read then zero clears", stat_rdata, 8'hC0);
    cyc(2);
    chk("R6 no refire while held", stat_rdata, 8'hC0);
    run(2);
    cyc(1);
    chk("R6 flag B set", stat_rdata, 8'hC2);
    chk("R11 irq_b masked", irq_b, 1'b0);

    // R8 clear protocol
    wr(8'h00);
    chk("R8 zero without read", stat_rdata, 8'hC2);
    rd(rv); wr(8'hFF);
    chk("R8 one write", stat_rdata, 8'hC2);
    wr(8'h00);
    chk("R8 arm consumed", stat_rdata, 8'hC2);
    rd(rv); wr(8'h00);
    chk("R8 cleared", stat_rdata, 8'hC0);

    // R9 DMA clear
    grw(1'b1, 16'h0010);
    ld(16'h000F, 1'b1);
    run(1);
    cyc(1);
    chk("R9 both set", stat_rdata, 8'hC3);
    dma_ack_a = 1'b1; cyc(1); dma_ack_a = 1'b0;
    chk("R9 dma clears A only", stat_rdata, 8'hC2);

    // R10 set over clear
    ld(16'h000F, 1'b1);
    run(1);
    cyc(1);
    rd(rv);
    chk("R10 armed read", rv, 8'hC3);
    ld(16'h000F, 1'b1);
    cnt_en = 1'b1; cyc(1); cnt_en = 1'b0;
    wr(8'h00);
    chk("R10 set beats write clear", stat_rdata, 8'hC3);
    ld(16'h000F, 1'b1);
    cnt_en = 1'b1; cyc(1); cnt_en = 1'b0;
    dma_ack_a = 1'b1; cyc(1); dma_ack_a = 1'b0;
    chk("R10 set beats dma clear", stat_rdata[0], 1'b1);

    // R7 capture
    clr_all();
    chk("R7 precleared", stat_rdata, 8'hC0);
    mode_a_cap = 1'b1;
    ld(16'h1234, 1'b1);
    cap_a_in = 1'b1; cyc(1);
    chk("R7 captured value", gr_a_q, 16'h1234);
    chk("R7 flag A", stat_rdata, 8'hC1);
    clr_all();
    cyc(2);
    chk("R7 no match flag in capture", stat_rdata, 8'hC0);
    ld(16'h2000, 1'b1);
    cyc(1);
    chk("R7 held level no capture", gr_a_q, 16'h1234);
    cap_a_in = 1'b0; cyc(1);
    cap_a_in = 1'b1; cyc(1);
    chk("R7 second edge", gr_a_q, 16'h2000);
    cap_a_in = 1'b0;

    // R11 overflow interrupt gating
    clr_all();
    ld(16'hFFFF, 1'b1);
    run(1);
    chk("R4 overflow status", stat_rdata, 8'hD0);
    chk("R11 irq_ovf on", {irq_ovf, irq_unf}, 2'b10);
    ie_ovf = 1'b0; #1;
    chk("R11 irq_ovf masked", irq_ovf, 1'b0);

    summary();
  end
endmodule